// File: doc/BRIEF.md
# Headerless Instruction-Sequence Decoder

This block sits between a micro-program store and the data path of a finite-field arithmetic coprocessor. Instruction words of 32 bits arrive one at a time over a valid/ready handshake. Each operation is set up by one to three words. No word carries a type tag, so the decoder infers the type of each word from where it sits in the sequence and from fields of the opening word. The opening word sets up the arithmetic unit. A memory-request bit in it calls for a memory word next. A zero-valued operand select, on either side, means a constant operand and calls for a constant word last.

Every field of every word type is latched into a registered control output. Those outputs hold until the next opening word is accepted. One cycle after the last word of a sequence is accepted, the block emits two pulses. The transfer-start pulse carries the start bit of the opening word. The program-done pulse carries its end-of-program bit.

Top module: `vliw_seq_decoder`

## Requirements
- R1: While `rst_n` is low, and until the first word is accepted after reset, every control output and both pulse outputs are 0.
- R2: An accepted opening word is latched as follows. Bits 31:30 go to `alu_sel_a` and 29:28 to `alu_sel_b`. Bits 27:25 go to `out_sel_1` and 24:22 to `out_sel_2`. Bits 21:16 go to `load_a`, 15:11 to `load_b` and 10:5 to `res_req`. Bits 4:3 go to `addsub_mode`. Bit 2 is the memory request, bit 1 is end-of-program and bit 0 is start. The outputs show these values in the next cycle.
- R3: If the memory-request bit of the opening word is 1, the next accepted word is a memory word. From it, bits 31:30 go to `mem_a_mux`, 29:20 to `mem_a_addr`, 19 to `mem_a_en` and 18 to `mem_a_we`. Bits 17:16 go to `mem_b_mux`, 15:6 to `mem_b_addr`, 5 to `mem_b_en` and 4 to `mem_b_we`.
- R4: If bits 31:30 or bits 29:28 of the opening word equal 2'b00, the last word of the sequence is a constant word. Its bits 31:28 go to `const_addr_a` and bits 27:24 go to `const_addr_b`.
- R5: The words come in a strict order: opening word, then the memory word if one is requested, then the constant word if one is required. Sequences are 1, 2 or 3 words long, and no pulse appears before the last word is accepted.
- R6: `xfer_start` is high for exactly one cycle, the cycle after the last word of a sequence is accepted, and it equals the start bit of the opening word. At every other time it is 0.
- R7: `prog_done` is high for exactly one cycle, the cycle after the last word is accepted, when the end-of-program bit of the opening word was 1. At every other time it is 0.
- R8: While no word is accepted, every control output keeps its value, whatever appears on `in_word`.
- R9: Accepting an opening word clears the memory-port and constant-address outputs to 0. They stay 0 unless the same sequence supplies a memory word or a constant word.
- R10: Bits 3:0 of a memory word and bits 23:0 of a constant word have no effect on any output.
- R11: `in_ready` is 1 whenever `rst_n` is high. Every word is decoded in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction word valid |
| in_word | input | 32 | Instruction word |
| in_ready | output | 1 | Decoder can accept a word |
| alu_sel_a | output | 2 | ALU operand A select (00 = constant) |
| alu_sel_b | output | 2 | ALU operand B select (00 = constant) |
| out_sel_1 | output | 3 | Unit routed to ALU result output 1 |
| out_sel_2 | output | 3 | Unit routed to ALU result output 2 |
| load_a | output | 6 | Per-unit operand-bus-valid strobes, group A |
| load_b | output | 5 | Per-unit operand-bus-valid strobes, group B |
| res_req | output | 6 | Per-unit result-request strobes |
| addsub_mode | output | 2 | Add/subtract mode per adder unit |
| mem_a_mux | output | 2 | Memory port A input mux select |
| mem_a_addr | output | 10 | Memory port A address |
| mem_a_en | output | 1 | Memory port A enable |
| mem_a_we | output | 1 | Memory port A write enable |
| mem_b_mux | output | 2 | Memory port B input mux select |
| mem_b_addr | output | 10 | Memory port B address |
| mem_b_en | output | 1 | Memory port B enable |
| mem_b_we | output | 1 | Memory port B write enable |
| const_addr_a | output | 4 | Constant table address for operand A |
| const_addr_b | output | 4 | Constant table address for operand B |
| xfer_start | output | 1 | Transfer-start pulse |
| prog_done | output | 1 | End-of-program pulse |

## Verification
The bench walks all 128 combinations of both operand selects, the memory-request bit, the end-of-program bit and the start bit, which covers every sequence length and every path through the type inference. A decoder that tested only one operand select for the constant word would stop one word early. It would then pulse before the constant word, or take the constant word as a new opening word, and the latched selects would come out wrong. A decoder that failed to clear the memory and constant outputs on a new opening word would leave the previous sequence's addresses and enables on the outputs, and the checks made right after each opening word catch this. Sequences follow each other both back to back and with idle gaps that carry junk on `in_word`. The junk and the ignored low bits catch a pulse that lasts two cycles, fields that load without a handshake, and ignored bits that leak into an output.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  localparam int WORD_W   = 32;
  localparam int SEL_W    = 2;
  localparam int OSEL_W   = 3;
  localparam int LDA_W    = 6;
  localparam int LDB_W    = 5;
  localparam int REQ_W    = 6;
  localparam int MODE_W   = 2;
  localparam int MUX_W    = 2;
  localparam int MADDR_W  = 10;
  localparam int CADDR_W  = 4;

  localparam logic [SEL_W-1:0] SEL_CONST = '0;

  typedef enum logic [1:0] {
    WAIT_CFG   = 2'd0,
    WAIT_MEM   = 2'd1,
    WAIT_CONST = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel_a;
    logic [SEL_W-1:0]  sel_b;
    logic [OSEL_W-1:0] osel_1;
    logic [OSEL_W-1:0] osel_2;
    logic [LDA_W-1:0]  ld_a;
    logic [LDB_W-1:0]  ld_b;
    logic [REQ_W-1:0]  req;
    logic [MODE_W-1:0] mode;
    logic              mem_req;
    logic              end_prog;
    logic              start;
  } cfg_word_t;

  typedef struct packed {
    logic [MUX_W-1:0]   mux_a;
    logic [MADDR_W-1:0] addr_a;
    logic               en_a;
    logic               we_a;
    logic [MUX_W-1:0]   mux_b;
    logic [MADDR_W-1:0] addr_b;
    logic               en_b;
    logic               we_b;
  } mem_word_t;

  typedef struct packed {
    logic [CADDR_W-1:0] caddr_a;
    logic [CADDR_W-1:0] caddr_b;
  } const_word_t;

  localparam int MEM_PAD_W   = WORD_W - $bits(mem_word_t);
  localparam int CONST_PAD_W = WORD_W - $bits(const_word_t);

  function automatic mem_word_t unpack_mem(input logic [WORD_W-1:0] w);
    return mem_word_t'(w[WORD_W-1:MEM_PAD_W]);
  endfunction

  function automatic const_word_t unpack_const(input logic [WORD_W-1:0] w);
    return const_word_t'(w[WORD_W-1:CONST_PAD_W]);
  endfunction

endpackage

// File: rtl/vsd_seq_ctrl.sv
module vsd_seq_ctrl
  import vsd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic cfg_mem_req,
  input  logic cfg_const_req,
  output logic is_cfg,
  output logic is_mem,
  output logic is_const,
  output logic seq_last
);

  seq_state_e state_q, state_d;
  logic       need_const_q, need_const_d;

  assign is_cfg   = (state_q == WAIT_CFG);
  assign is_mem   = (state_q == WAIT_MEM);
  assign is_const = (state_q == WAIT_CONST);

  always_comb begin
    state_d      = state_q;
    need_const_d = need_const_q;
    seq_last     = 1'b0;
    if (accept) begin
      unique case (state_q)
        WAIT_CFG: begin
          need_const_d = cfg_const_req;
          if (cfg_mem_req)        state_d = WAIT_MEM;
          else if (cfg_const_req) state_d = WAIT_CONST;
          else                    seq_last = 1'b1;
        end
        WAIT_MEM: begin
          if (need_const_q) state_d = WAIT_CONST;
          else begin
            state_d  = WAIT_CFG;
            seq_last = 1'b1;
          end
        end
        WAIT_CONST: begin
          state_d  = WAIT_CFG;
          seq_last = 1'b1;
        end
        default: state_d = WAIT_CFG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= WAIT_CFG;
      need_const_q <= 1'b0;
    end else if (accept) begin
      state_q      <= state_d;
      need_const_q <= need_const_d;
    end
  end

endmodule

// File: rtl/vsd_field_bank.sv
module vsd_field_bank
  import vsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cfg,
  input  logic              ld_mem,
  input  logic              ld_const,
  input  logic [WORD_W-1:0] word,
  output cfg_word_t         cfg_q,
  output mem_word_t         mem_q,
  output const_word_t       cst_q
);

  cfg_word_t   cfg_d;
  mem_word_t   mem_d;
  const_word_t cst_d;
  logic        mem_en, cst_en;

  assign mem_en = ld_cfg | ld_mem;
  assign cst_en = ld_cfg | ld_const;

  always_comb begin
    cfg_d = cfg_word_t'(word);
    mem_d = ld_cfg ? '0 : unpack_mem(word);
    cst_d = ld_cfg ? '0 : unpack_const(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      mem_q <= '0;
      cst_q <= '0;
    end else begin
      if (ld_cfg) cfg_q <= cfg_d;
      if (mem_en) mem_q <= mem_d;
      if (cst_en) cst_q <= cst_d;
    end
  end

endmodule

// File: rtl/vsd_pulse_gen.sv
module vsd_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic from_word,
  input  logic word_start,
  input  logic word_end,
  input  logic held_start,
  input  logic held_end,
  output logic xfer_start,
  output logic prog_done
);

  logic start_d, done_d;

  always_comb begin
    start_d = 1'b0;
    done_d  = 1'b0;
    if (fire) begin
      start_d = from_word ? word_start : held_start;
      done_d  = from_word ? word_end   : held_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start <= 1'b0;
      prog_done  <= 1'b0;
    end else begin
      xfer_start <= start_d;
      prog_done  <= done_d;
    end
  end

endmodule

// File: rtl/vliw_seq_decoder.sv
module vliw_seq_decoder
  import vsd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_word,
  output logic                in_ready,
  output logic [SEL_W-1:0]    alu_sel_a,
  output logic [SEL_W-1:0]    alu_sel_b,
  output logic [OSEL_W-1:0]   out_sel_1,
  output logic [OSEL_W-1:0]   out_sel_2,
  output logic [LDA_W-1:0]    load_a,
  output logic [LDB_W-1:0]    load_b,
  output logic [REQ_W-1:0]    res_req,
  output logic [MODE_W-1:0]   addsub_mode,
  output logic [MUX_W-1:0]    mem_a_mux,
  output logic [MADDR_W-1:0]  mem_a_addr,
  output logic                mem_a_en,
  output logic                mem_a_we,
  output logic [MUX_W-1:0]    mem_b_mux,
  output logic [MADDR_W-1:0]  mem_b_addr,
  output logic                mem_b_en,
  output logic                mem_b_we,
  output logic [CADDR_W-1:0]  const_addr_a,
  output logic [CADDR_W-1:0]  const_addr_b,
  output logic                xfer_start,
  output logic                prog_done
);

  logic        accept;
  logic        is_cfg, is_mem, is_const, seq_last;
  cfg_word_t   cur_cfg;
  cfg_word_t   cfg_q;
  mem_word_t   mem_q;
  const_word_t cst_q;
  logic        cur_const_req;

  // Single-cycle decode: never stalls the source.
  assign in_ready      = 1'b1;
  assign accept        = in_valid & in_ready;
  assign cur_cfg       = cfg_word_t'(in_word);
  assign cur_const_req = (cur_cfg.sel_a == SEL_CONST) | (cur_cfg.sel_b == SEL_CONST);

  vsd_seq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .cfg_mem_req   (cur_cfg.mem_req),
    .cfg_const_req (cur_const_req),
    .is_cfg        (is_cfg),
    .is_mem        (is_mem),
    .is_const      (is_const),
    .seq_last      (seq_last)
  );

  vsd_field_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_cfg   (accept & is_cfg),
    .ld_mem   (accept & is_mem),
    .ld_const (accept & is_const),
    .word     (in_word),
    .cfg_q    (cfg_q),
    .mem_q    (mem_q),
    .cst_q    (cst_q)
  );

  vsd_pulse_gen u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (seq_last),
    .from_word  (is_cfg),
    .word_start (cur_cfg.start),
    .word_end   (cur_cfg.end_prog),
    .held_start (cfg_q.start),
    .held_end   (cfg_q.end_prog),
    .xfer_start (xfer_start),
    .prog_done  (prog_done)
  );

  assign alu_sel_a    = cfg_q.sel_a;
  assign alu_sel_b    = cfg_q.sel_b;
  assign out_sel_1    = cfg_q.osel_1;
  assign out_sel_2    = cfg_q.osel_2;
  assign load_a       = cfg_q.ld_a;
  assign load_b       = cfg_q.ld_b;
  assign res_req      = cfg_q.req;
  assign addsub_mode  = cfg_q.mode;
  assign mem_a_mux    = mem_q.mux_a;
  assign mem_a_addr   = mem_q.addr_a;
  assign mem_a_en     = mem_q.en_a;
  assign mem_a_we     = mem_q.we_a;
  assign mem_b_mux    = mem_q.mux_b;
  assign mem_b_addr   = mem_q.addr_b;
  assign mem_b_en     = mem_q.en_b;
  assign mem_b_we     = mem_q.we_b;
  assign const_addr_a = cst_q.caddr_a;
  assign const_addr_b = cst_q.caddr_b;

endmodule

// File: rtl/vsd_checker.sv
module vsd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        xfer_start,
  input logic        prog_done,
  input logic [1:0]  alu_sel_a,
  input logic [5:0]  load_a,
  input logic [9:0]  mem_a_addr,
  input logic        mem_a_en,
  input logic [3:0]  const_addr_a
);

  assert_start_needs_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(in_valid && in_ready));

  assert_done_needs_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> $past(in_valid && in_ready));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> ($stable(alu_sel_a) && $stable(load_a)));

  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> ($stable(mem_a_addr) && $stable(mem_a_en)));

  assert_const_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> $stable(const_addr_a));

endmodule

bind vliw_seq_decoder vsd_checker u_vsd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .xfer_start   (xfer_start),
  .prog_done    (prog_done),
  .alu_sel_a    (alu_sel_a),
  .load_a       (load_a),
  .mem_a_addr   (mem_a_addr),
  .mem_a_en     (mem_a_en),
  .const_addr_a (const_addr_a)
);

// File: tb/vliw_seq_decoder_test.sv
`timescale 1ns/1ps
module vliw_seq_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        in_ready;
  logic [1:0]  alu_sel_a, alu_sel_b;
  logic [2:0]  out_sel_1, out_sel_2;
  logic [5:0]  load_a;
  logic [4:0]  load_b;
  logic [5:0]  res_req;
  logic [1:0]  addsub_mode;
  logic [1:0]  mem_a_mux, mem_b_mux;
  logic [9:0]  mem_a_addr, mem_b_addr;
  logic        mem_a_en, mem_a_we, mem_b_en, mem_b_we;
  logic [3:0]  const_addr_a, const_addr_b;
  logic        xfer_start, prog_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vliw_seq_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .out_sel_1(out_sel_1), .out_sel_2(out_sel_2),
    .load_a(load_a), .load_b(load_b), .res_req(res_req), .addsub_mode(addsub_mode),
    .mem_a_mux(mem_a_mux), .mem_a_addr(mem_a_addr), .mem_a_en(mem_a_en), .mem_a_we(mem_a_we),
    .mem_b_mux(mem_b_mux), .mem_b_addr(mem_b_addr), .mem_b_en(mem_b_en), .mem_b_we(mem_b_we),
    .const_addr_a(const_addr_a), .const_addr_b(const_addr_b),
    .xfer_start(xfer_start), .prog_done(prog_done)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected values of the latched fields, kept by the bench.
  logic [31:0] e_cfg;
  logic [1:0]  e_ma_mux, e_mb_mux;
  logic [9:0]  e_ma_addr, e_mb_addr;
  logic        e_ma_en, e_ma_we, e_mb_en, e_mb_we;
  logic [3:0]  e_ca, e_cb;

  task automatic chk_cfg(input string req);
    chk(req, "alu_sel_a",   alu_sel_a,   e_cfg[31:30]);
    chk(req, "alu_sel_b",   alu_sel_b,   e_cfg[29:28]);
    chk(req, "out_sel_1",   out_sel_1,   e_cfg[27:25]);
    chk(req, "out_sel_2",   out_sel_2,   e_cfg[24:22]);
    chk(req, "load_a",      load_a,      e_cfg[21:16]);
    chk(req, "load_b",      load_b,      e_cfg[15:11]);
    chk(req, "res_req",     res_req,     e_cfg[10:5]);
    chk(req, "addsub_mode", addsub_mode, e_cfg[4:3]);
  endtask

  task automatic chk_mem(input string req);
    chk(req, "mem_a_mux",  mem_a_mux,  e_ma_mux);
    chk(req, "mem_a_addr", mem_a_addr, e_ma_addr);
    chk(req, "mem_a_en",   mem_a_en,   e_ma_en);
    chk(req, "mem_a_we",   mem_a_we,   e_ma_we);
    chk(req, "mem_b_mux",  mem_b_mux,  e_mb_mux);
    chk(req, "mem_b_addr", mem_b_addr, e_mb_addr);
    chk(req, "mem_b_en",   mem_b_en,   e_mb_en);
    chk(req, "mem_b_we",   mem_b_we,   e_mb_we);
  endtask

  task automatic chk_const(input string req);
    chk(req, "const_addr_a", const_addr_a, e_ca);
    chk(req, "const_addr_b", const_addr_b, e_cb);
  endtask

  task automatic clear_exp();
    e_cfg = '0;
    e_ma_mux = '0; e_ma_addr = '0; e_ma_en = 1'b0; e_ma_we = 1'b0;
    e_mb_mux = '0; e_mb_addr = '0; e_mb_en = 1'b0; e_mb_we = 1'b0;
    e_ca = '0; e_cb = '0;
  endtask

  // Present a word, let one edge accept it, return at the next falling edge.
  task automatic send(input logic [31:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    clear_exp();
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk_cfg("R1"); chk_mem("R1"); chk_const("R1");
    chk("R1", "xfer_start", xfer_start, 1'b0);
    chk("R1", "prog_done",  prog_done,  1'b0);
    rst_n = 1'b1;
    in_word = 32'hFFFF_FFFF;
    @(negedge clk);
    chk_cfg("R1"); chk_mem("R1"); chk_const("R1");
    chk("R11", "in_ready", in_ready, 1'b1);

    for (int i = 0; i < 128; i++) begin
      logic [1:0] ai, bi;
      logic       ma, rt, st, need3, last1;
      logic [31:0] w1, w2, w3;
      ai = i[1:0]; bi = i[3:2]; ma = i[4]; rt = i[5]; st = i[6];
      need3 = (ai == 2'b00) || (bi == 2'b00);
      last1 = !ma && !need3;
      w1 = {ai, bi, 3'((i * 3) % 8), 3'((i * 5 + 1) % 8), 6'((i * 7) % 64),
            5'((i * 11 + 2) % 32), 6'((i * 13 + 5) % 64), 2'(i % 4), ma, rt, st};
      w2 = {2'((i + 1) % 4), 10'((i * 37) % 1024), i[0], i[1],
            2'((i + 2) % 4), 10'((i * 53 + 7) % 1024), i[2], i[3], 4'(~i)};
      w3 = {4'(i % 16), 4'((i * 7 + 3) % 16), 24'(i * 12345)};

      // R2 / R9: opening word latched, memory and constant outputs cleared
      clear_exp();
      e_cfg = w1;
      send(w1);
      chk_cfg("R2");
      chk_mem("R9");
      chk_const("R9");
      chk("R11", "in_ready", in_ready, 1'b1);
      if (!last1) begin
        chk("R5", "early xfer_start", xfer_start, 1'b0);
        chk("R5", "early prog_done",  prog_done,  1'b0);
      end

      if (ma) begin
        e_ma_mux = w2[31:30]; e_ma_addr = w2[29:20]; e_ma_en = w2[19]; e_ma_we = w2[18];
        e_mb_mux = w2[17:16]; e_mb_addr = w2[15:6];  e_mb_en = w2[5];  e_mb_we = w2[4];
        send(w2);
        chk_mem("R3");
        chk_const("R10");
        chk_cfg("R5");
        if (need3) chk("R5", "early xfer_start", xfer_start, 1'b0);
      end

      if (need3) begin
        e_ca = w3[31:28]; e_cb = w3[27:24];
        send(w3);
        chk_const("R4");
        chk_mem("R10");
        chk_cfg("R5");
      end

      // R6 / R7: pulses in the cycle after the last word
      chk("R6", "xfer_start", xfer_start, st);
      chk("R7", "prog_done",  prog_done,  rt);

      if (i % 3 == 0) begin
        @(negedge clk);
        chk("R6", "xfer_start width", xfer_start, 1'b0);
        chk("R7", "prog_done width",  prog_done,  1'b0);
        in_word = 32'h0000_0004 ^ w2;
        @(negedge clk);
        chk_cfg("R8"); chk_mem("R8"); chk_const("R8");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule